// File: doc/BRIEF.md
# Return-Address Stack

This block is a dedicated last-in, first-out store for program counter values, kept apart from program and data memory. A call pushes the address of the instruction after the call. A return pops the most recent entry, and the block presents that entry on a registered output for the program counter to load. The sequencer that decodes the instructions and steps the program counter sits outside this block.

The stack has 31 storage slots of 21 bits. They are addressed by a 5-bit pointer that counts the slots in use. Pointer value 0 means the stack is empty and has no storage behind it. A push advances the pointer before it stores. A pop reads the slot the pointer names and then steps the pointer back.

Software reaches the block through a small byte-wide register port with four selectable registers. One register is a status byte that holds the pointer, the full flag and two sticky error flags. The other three are the top entry split into low, high and upper bytes. The pointer can be rewritten at any time, so software can save and restore the stack or unwind it by hand.

Top module: `ret_stack`

## Requirements
- R1: After reset the pointer is 0, the overflow, underflow and full flags are 0, ret_pc_o is 0 and ret_vld_o is 0.
- R2: A push alone at a pointer below 31 raises the pointer by one and stores pc_i in the slot the new pointer names. That value is then the top entry.
- R3: A pop alone at a nonzero pointer puts the top entry on ret_pc_o one cycle later, pulses ret_vld_o for that one cycle and lowers the pointer by one. Pops return entries in the reverse order of their pushes. ret_vld_o is 0 in any cycle that does not follow a pop.
- R4: full_o is 1 exactly when the pointer is 31.
- R5: A push alone at pointer 31 sets ovf_o and leaves the pointer and the stored entries unchanged. ovf_o stays set until software clears it.
- R6: A pop at pointer 0 sets unf_o, returns 0 on ret_pc_o with ret_vld_o set, and leaves the pointer at 0. unf_o stays set until software clears it.
- R7: The status register (select 0) reads as bits 4:0 pointer, bit 5 full, bit 6 underflow, bit 7 overflow. A write loads the pointer from bits 4:0. Writing 0 to bit 7 or bit 6 clears that flag, and writing 1 leaves it as it was. Bit 5 is read-only.
- R8: Selects 1, 2 and 3 read and write the top entry's bits 7:0, 15:8 and 20:16. The upper register uses bits 4:0, and its bits 7:5 read 0. A write changes only its own byte of the top entry.
- R9: While the pointer is 0, all three top-entry registers read 0 and writes to them have no effect.
- R10: A push and a pop in the same cycle replace the top entry. The old entry goes to ret_pc_o with ret_vld_o set, pc_i takes its slot, and the pointer does not change. At pointer 0 this behaves as a pop at pointer 0 (R6).
- R11: When a push or pop occurs in the same cycle as a register write, the stack operation is carried out and the register write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| push_i | input | 1 | Call: push pc_i |
| pop_i | input | 1 | Return: pop top entry |
| pc_i | input | 21 | Return address to push |
| ret_pc_o | output | 21 | Address returned by the last pop |
| ret_vld_o | output | 1 | One-cycle pulse after a pop |
| full_o | output | 1 | Pointer is at 31 |
| ovf_o | output | 1 | Sticky overflow flag |
| unf_o | output | 1 | Sticky underflow flag |
| ptr_o | output | 5 | Current pointer |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 status, 1 low, 2 high, 3 upper |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for the selected register |

## Verification
The bench fills the stack to its last slot and empties it again. It checks the pointer, the full flag and the top entry after each push, and the returned order after each pop. This catches an off-by-one that would lose slot 31 or read slot 0 as storage. It then pushes at full and pops at empty, where a faulty design would wrap the pointer or corrupt a slot instead of setting a sticky flag. It also checks byte writes to the top entry, which a wrong merge would spill into a neighbouring byte. Last come the replace case and the case of a stack operation colliding with a register write, where a wrong priority shows up as a wrong pointer or a wrong return value.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;
  localparam int REG_W    = 8;
  localparam int STAT_FUL = 5;
  localparam int STAT_UNF = 6;
  localparam int STAT_OVF = 7;

  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_TOSL = 2'd1,
    SEL_TOSH = 2'd2,
    SEL_TOSU = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/ret_stack_mem.sv
module ret_stack_mem #(
  parameter int PC_W  = 21,
  parameter int DEPTH = 31,
  localparam int PTR_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_q_n,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  logic [PC_W-1:0]  wdata,
  input  logic [PTR_W-1:0] raddr,
  output logic [PC_W-1:0]  rdata
);
  logic [PC_W-1:0] slot_q [1:DEPTH];

  for (genvar g = 1; g <= DEPTH; g++) begin : g_slot
    logic slot_en;
    assign slot_en = we && (waddr == PTR_W'(g));
    always_ff @(posedge clk or negedge rst_q_n) begin
      if (!rst_q_n)     slot_q[g] <= '0;
      else if (slot_en) slot_q[g] <= wdata;
    end
  end

  // Address 0 is the empty state: no storage, reads as zero.
  always_comb begin
    rdata = '0;
    for (int i = 1; i <= DEPTH; i++) begin
      if (raddr == PTR_W'(i)) rdata = slot_q[i];
    end
  end
endmodule

// File: rtl/ret_stack_regif.sv
module ret_stack_regif
  import ret_stack_pkg::*;
#(
  parameter int PC_W  = 21,
  parameter int DEPTH = 31,
  localparam int PTR_W = $clog2(DEPTH + 1),
  localparam int UP_W  = PC_W - 16
) (
  input  logic             reg_we_i,
  input  logic [1:0]       reg_sel_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  input  logic [PC_W-1:0]  tos,
  input  logic [PTR_W-1:0] ptr,
  input  logic             ovf,
  input  logic             unf,
  input  logic             full,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             ptr_we,
  output logic             tos_we,
  output logic [PC_W-1:0]  tos_wdata
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(reg_sel_i);

  always_comb begin
    reg_rdata_o = '0;
    case (sel)
      SEL_STAT: begin
        reg_rdata_o[PTR_W-1:0] = ptr;
        reg_rdata_o[STAT_FUL]  = full;
        reg_rdata_o[STAT_UNF]  = unf;
        reg_rdata_o[STAT_OVF]  = ovf;
      end
      SEL_TOSL: reg_rdata_o = tos[7:0];
      SEL_TOSH: reg_rdata_o = tos[15:8];
      default:  reg_rdata_o[UP_W-1:0] = tos[PC_W-1:16];
    endcase
  end

  always_comb begin
    tos_wdata = tos;
    case (sel)
      SEL_TOSL: tos_wdata[7:0]       = reg_wdata_i;
      SEL_TOSH: tos_wdata[15:8]      = reg_wdata_i;
      SEL_TOSU: tos_wdata[PC_W-1:16] = reg_wdata_i[UP_W-1:0];
      default:  tos_wdata            = tos;
    endcase
  end

  assign ptr_we = reg_we_i && (sel == SEL_STAT);
  assign tos_we = reg_we_i && (sel != SEL_STAT);
endmodule

// File: rtl/ret_stack_ctrl.sv
module ret_stack_ctrl
  import ret_stack_pkg::*;
#(
  parameter int PC_W  = 21,
  parameter int DEPTH = 31,
  localparam int PTR_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_q_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [PC_W-1:0]  tos,
  input  logic             sw_ptr_we,
  input  logic [REG_W-1:0] sw_wdata,
  input  logic             sw_tos_we,
  input  logic [PC_W-1:0]  sw_tos_wdata,
  output logic [PTR_W-1:0] ptr_q,
  output logic             ovf_q,
  output logic             unf_q,
  output logic [PC_W-1:0]  ret_pc_q,
  output logic             ret_vld_q,
  output logic             mem_we,
  output logic [PTR_W-1:0] mem_waddr,
  output logic [PC_W-1:0]  mem_wdata
);
  localparam logic [PTR_W-1:0] PTR_TOP = PTR_W'(DEPTH);

  logic [PTR_W-1:0] ptr_d, sw_ptr;
  logic             ovf_d, unf_d, ret_vld_d, ptr_en, flag_en;
  logic [PC_W-1:0]  ret_pc_d;
  logic             at_top, at_empty;

  assign at_top   = (ptr_q == PTR_TOP);
  assign at_empty = (ptr_q == '0);
  assign sw_ptr   = (sw_wdata[PTR_W-1:0] > PTR_TOP) ? PTR_TOP : sw_wdata[PTR_W-1:0];

  always_comb begin
    ptr_d     = ptr_q;
    ovf_d     = ovf_q;
    unf_d     = unf_q;
    ret_pc_d  = ret_pc_q;
    ret_vld_d = 1'b0;
    mem_we    = 1'b0;
    mem_waddr = ptr_q;
    mem_wdata = pc_i;
    if (push_i && pop_i) begin
      ret_vld_d = 1'b1;
      if (at_empty) begin
        unf_d    = 1'b1;
        ret_pc_d = '0;
      end else begin
        ret_pc_d = tos;
        mem_we   = 1'b1;
      end
    end else if (push_i) begin
      if (at_top) begin
        ovf_d = 1'b1;
      end else begin
        ptr_d     = ptr_q + 1'b1;
        mem_we    = 1'b1;
        mem_waddr = ptr_q + 1'b1;
      end
    end else if (pop_i) begin
      ret_vld_d = 1'b1;
      if (at_empty) begin
        unf_d    = 1'b1;
        ret_pc_d = '0;
      end else begin
        ret_pc_d = tos;
        ptr_d    = ptr_q - 1'b1;
      end
    end else if (sw_ptr_we) begin
      ptr_d = sw_ptr;
      ovf_d = ovf_q & sw_wdata[STAT_OVF];
      unf_d = unf_q & sw_wdata[STAT_UNF];
    end else if (sw_tos_we && !at_empty) begin
      mem_we    = 1'b1;
      mem_wdata = sw_tos_wdata;
    end
  end

  assign ptr_en  = (ptr_d != ptr_q);
  assign flag_en = (ovf_d != ovf_q) || (unf_d != unf_q);

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ptr_q     <= '0;
      ovf_q     <= 1'b0;
      unf_q     <= 1'b0;
      ret_pc_q  <= '0;
      ret_vld_q <= 1'b0;
    end else begin
      if (ptr_en)    ptr_q    <= ptr_d;
      if (flag_en) begin
        ovf_q <= ovf_d;
        unf_q <= unf_d;
      end
      if (ret_vld_d) ret_pc_q <= ret_pc_d;
      ret_vld_q <= ret_vld_d;
    end
  end
endmodule

// File: rtl/ret_stack.sv
module ret_stack
  import ret_stack_pkg::*;
#(
  parameter int PC_W  = 21,
  parameter int DEPTH = 31,
  localparam int PTR_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [PC_W-1:0]  pc_i,
  output logic [PC_W-1:0]  ret_pc_o,
  output logic             ret_vld_o,
  output logic             full_o,
  output logic             ovf_o,
  output logic             unf_o,
  output logic [PTR_W-1:0] ptr_o,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_sel_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_q_n;
  logic [PC_W-1:0]  tos, sw_tos_wdata, mem_wdata;
  logic [PTR_W-1:0] mem_waddr;
  logic             sw_ptr_we, sw_tos_we, mem_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  assign full_o = (ptr_o == PTR_W'(DEPTH));

  ret_stack_regif #(.PC_W(PC_W), .DEPTH(DEPTH)) u_regif (
    .reg_we_i    (reg_we_i),
    .reg_sel_i   (reg_sel_i),
    .reg_wdata_i (reg_wdata_i),
    .tos         (tos),
    .ptr         (ptr_o),
    .ovf         (ovf_o),
    .unf         (unf_o),
    .full        (full_o),
    .reg_rdata_o (reg_rdata_o),
    .ptr_we      (sw_ptr_we),
    .tos_we      (sw_tos_we),
    .tos_wdata   (sw_tos_wdata)
  );

  ret_stack_ctrl #(.PC_W(PC_W), .DEPTH(DEPTH)) u_ctrl (
    .clk          (clk),
    .rst_q_n      (rst_q_n),
    .push_i       (push_i),
    .pop_i        (pop_i),
    .pc_i         (pc_i),
    .tos          (tos),
    .sw_ptr_we    (sw_ptr_we),
    .sw_wdata     (reg_wdata_i),
    .sw_tos_we    (sw_tos_we),
    .sw_tos_wdata (sw_tos_wdata),
    .ptr_q        (ptr_o),
    .ovf_q        (ovf_o),
    .unf_q        (unf_o),
    .ret_pc_q     (ret_pc_o),
    .ret_vld_q    (ret_vld_o),
    .mem_we       (mem_we),
    .mem_waddr    (mem_waddr),
    .mem_wdata    (mem_wdata)
  );

  ret_stack_mem #(.PC_W(PC_W), .DEPTH(DEPTH)) u_mem (
    .clk     (clk),
    .rst_q_n (rst_q_n),
    .we      (mem_we),
    .waddr   (mem_waddr),
    .wdata   (mem_wdata),
    .raddr   (ptr_o),
    .rdata   (tos)
  );
endmodule

// File: rtl/ret_stack_chk.sv
module ret_stack_chk #(
  parameter int PC_W  = 21,
  parameter int DEPTH = 31,
  localparam int PTR_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_q_n,
  input logic             push_i,
  input logic             pop_i,
  input logic             reg_we_i,
  input logic [1:0]       reg_sel_i,
  input logic [7:0]       reg_wdata_i,
  input logic [PC_W-1:0]  ret_pc_o,
  input logic             ret_vld_o,
  input logic             ovf_o,
  input logic             unf_o,
  input logic [PTR_W-1:0] ptr_o
);
  localparam logic [PTR_W-1:0] TOP = PTR_W'(DEPTH);

  AST_PUSH_INC: assert property (@(posedge clk) disable iff (!rst_q_n)
    (push_i && !pop_i && ptr_o != TOP) |=> (ptr_o == $past(ptr_o) + 1'b1)); // R2

  AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_q_n)
    (pop_i && !push_i && ptr_o != '0) |=> (ret_vld_o && ptr_o == $past(ptr_o) - 1'b1)); // R3

  AST_NO_SPURIOUS_VLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    !pop_i |=> !ret_vld_o); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_q_n)
    (push_i && !pop_i && ptr_o == TOP) |=> (ovf_o && ptr_o == TOP)); // R5

  AST_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_q_n)
    (pop_i && ptr_o == '0) |=> (unf_o && ret_vld_o && ret_pc_o == '0 && ptr_o == '0)); // R6

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ovf_o && !(reg_we_i && reg_sel_i == 2'd0 && !push_i && !pop_i)) |=> ovf_o); // R5

  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_q_n)
    (unf_o && !(reg_we_i && reg_sel_i == 2'd0 && !reg_wdata_i[6])) |=> unf_o); // R6

  AST_REPLACE_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_q_n)
    (push_i && pop_i) |=> $stable(ptr_o)); // R10
endmodule

bind ret_stack ret_stack_chk #(.PC_W(PC_W), .DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_q_n     (rst_q_n),
  .push_i      (push_i),
  .pop_i       (pop_i),
  .reg_we_i    (reg_we_i),
  .reg_sel_i   (reg_sel_i),
  .reg_wdata_i (reg_wdata_i),
  .ret_pc_o    (ret_pc_o),
  .ret_vld_o   (ret_vld_o),
  .ovf_o       (ovf_o),
  .unf_o       (unf_o),
  .ptr_o       (ptr_o)
);

// File: tb/ret_stack_bench.sv
module ret_stack_bench;
  localparam int PC_W  = 21;
  localparam int DEPTH = 31;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            push_i = 1'b0, pop_i = 1'b0, reg_we_i = 1'b0;
  logic [PC_W-1:0] pc_i = '0;
  logic [1:0]      reg_sel_i = 2'd0;
  logic [7:0]      reg_wdata_i = 8'd0;
  logic [PC_W-1:0] ret_pc_o;
  logic            ret_vld_o, full_o, ovf_o, unf_o;
  logic [4:0]      ptr_o;
  logic [7:0]      reg_rdata_o;

  int checks = 0;
  int errors = 0;
  int model [1:DEPTH];

  always #10 clk = ~clk;

  ret_stack u_ret_stack (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i), .pc_i(pc_i),
    .ret_pc_o(ret_pc_o), .ret_vld_o(ret_vld_o), .full_o(full_o),
    .ovf_o(ovf_o), .unf_o(unf_o), .ptr_o(ptr_o), .reg_we_i(reg_we_i),
    .reg_sel_i(reg_sel_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o)
  );

  function automatic int pat(int i);
    return (i * 32'h1357B + 32'h0A5) & 32'h1FFFFF;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(logic pu, logic po, int pc, logic we, int sel, int wd);
    @(negedge clk);
    push_i = pu; pop_i = po; pc_i = PC_W'(pc);
    reg_we_i = we; reg_sel_i = 2'(sel); reg_wdata_i = 8'(wd);
    @(posedge clk);
    #1;
    push_i = 1'b0; pop_i = 1'b0; reg_we_i = 1'b0;
  endtask

  task automatic rd(int sel, output int val);
    reg_sel_i = 2'(sel);
    #1;
    val = int'(reg_rdata_o);
  endtask

  task automatic rd_tos(output int val);
    int l, h, u;
    rd(1, l); rd(2, h); rd(3, u);
    val = (u << 16) | (h << 8) | l;
  endtask

  int v;

  initial begin
    #(20 * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    rd(0, v);          check("R1 status", v, 0);
    check("R1 ret_pc", int'(ret_pc_o), 0);
    check("R1 ret_vld", int'(ret_vld_o), 0);
    rd_tos(v);         check("R9 tos empty", v, 0);
    // R9 write ignored while empty
    cyc(0, 0, 0, 1, 1, 8'hAA);
    rd_tos(v);         check("R9 write ignored", v, 0);
    check("R9 ptr", int'(ptr_o), 0);

    // R2/R4 fill sweep
    for (int i = 1; i <= DEPTH; i++) begin
      model[i] = pat(i);
      cyc(1, 0, model[i], 0, 0, 0);
      check("R2 ptr", int'(ptr_o), i);
      rd_tos(v);       check("R2 tos", v, model[i]);
      check("R4 full", int'(full_o), (i == DEPTH) ? 1 : 0);
    end

    // R5 push at full
    cyc(1, 0, 21'h0F0F0, 0, 0, 0);
    check("R5 ovf", int'(ovf_o), 1);
    check("R5 ptr", int'(ptr_o), DEPTH);
    rd_tos(v);         check("R5 tos kept", v, model[DEPTH]);
    cyc(0, 0, 0, 0, 0, 0);
    check("R5 sticky", int'(ovf_o), 1);

    // R7 status register
    rd(0, v);          check("R7 layout", v, 8'hBF);
    cyc(0, 0, 0, 1, 0, 8'hFF);
    rd(0, v);          check("R7 write ones keeps", v, 8'hBF);
    cyc(0, 0, 0, 1, 0, 8'h7F);
    rd(0, v);          check("R7 clear ovf", v, 8'h3F);

    // R8 byte writes of top entry
    cyc(0, 0, 0, 1, 1, 8'h11);
    rd_tos(v);         check("R8 low", v, (model[DEPTH] & 32'h1FFF00) | 32'h11);
    cyc(0, 0, 0, 1, 2, 8'h22);
    cyc(0, 0, 0, 1, 3, 8'hFF);
    rd(3, v);          check("R8 upper read", v, 8'h1F);
    rd_tos(v);         check("R8 all bytes", v, 32'h1F2211);
    model[DEPTH] = 32'h1F2211;

    // R11 pop collides with status write
    cyc(0, 1, 0, 1, 0, 8'h02);
    check("R11 ptr", int'(ptr_o), DEPTH - 1);
    check("R11 ret", int'(ret_pc_o), model[DEPTH]);

    // R10 replace
    cyc(1, 1, 21'h15A5A, 0, 0, 0);
    check("R10 ret", int'(ret_pc_o), model[DEPTH - 1]);
    check("R10 vld", int'(ret_vld_o), 1);
    check("R10 ptr", int'(ptr_o), DEPTH - 1);
    rd_tos(v);         check("R10 tos", v, 32'h15A5A);
    model[DEPTH - 1] = 32'h15A5A;

    // R3 drain in LIFO order
    for (int i = DEPTH - 1; i >= 1; i--) begin
      cyc(0, 1, 0, 0, 0, 0);
      check("R3 ret", int'(ret_pc_o), model[i]);
      check("R3 vld", int'(ret_vld_o), 1);
      check("R3 ptr", int'(ptr_o), i - 1);
    end
    cyc(0, 0, 0, 0, 0, 0);
    check("R3 vld drop", int'(ret_vld_o), 0);

    // R6 pop at empty
    cyc(0, 1, 0, 0, 0, 0);
    check("R6 unf", int'(unf_o), 1);
    check("R6 ret zero", int'(ret_pc_o), 0);
    check("R6 vld", int'(ret_vld_o), 1);
    check("R6 ptr", int'(ptr_o), 0);
    // R10 replace at empty behaves as underflow
    cyc(1, 1, 21'h1234, 0, 0, 0);
    check("R10 empty ptr", int'(ptr_o), 0);
    rd_tos(v);         check("R10 empty tos", v, 0);
    cyc(0, 0, 0, 0, 0, 0);
    check("R6 sticky", int'(unf_o), 1);
    cyc(0, 0, 0, 1, 0, 8'h80);
    rd(0, v);          check("R7 clear unf", v, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule